// File: doc/BRIEF.md
# Transceiver Interrupt Status and Masking Unit

This block sits between the event sources of a gigabit transceiver core and its management register port. Each of fifteen single-cycle event lines sets a sticky status bit. Two levels of masking then decide whether pending events reach a single active-high interrupt output. The first level is a per-event mask register and the second is one global mask bit.

Software reaches the unit through a parallel register port with a 5-bit address, 16-bit write and read data, and separate read and write strobes. Read data is combinational from the addressed register while the read strobe is high. Side effects of the access, such as clearing status, take place at the clock edge that ends the strobe cycle. A force bit in the control register can raise the interrupt with no event pending, which helps when checking the interrupt path. The interrupt output is registered, so it follows the state of the registers by one clock.

Top module: `phy_irq_unit`

## Requirements
- R1: After reset the control register (address 0x10) reads 0x1000, meaning the global mask is set and force is clear. The mask register (0x1B) reads 0x7FFF, the status register (0x1A) reads 0x0000 and the interrupt output is low.
- R2: A one-cycle high on event line i sets status bit i (i = 0..14) at the next clock edge, whether or not that event is masked.
- R3: Reading address 0x1A returns the latched status bits and clears all of them at the end of that read cycle. A second read with no new events returns 0.
- R4: An event that arrives in the same cycle as a status read is kept, and the next status read reports it.
- R5: In mask register 0x1B, bit i = 1 blocks event i and bit i = 0 passes it. With the global mask clear, the interrupt output is high one clock after any status bit whose mask bit is 0 is set.
- R6: While control bit 12 (global mask) is 1, the interrupt output stays low whatever is pending or forced.
- R7: Control bit 11 (force) drives the interrupt output high one clock after it is written to 1 with the global mask clear, even when no event is pending.
- R8: Bit 12 of the extended status register (0x11) reads the current interrupt output, and its other bits read 0.
- R9: Writes to 0x1A and 0x11 have no effect. Reads of addresses outside 0x10, 0x11, 0x1A and 0x1B return 0. Bit 15 of the status and mask registers always reads 0.
- R10: All 16 bits of the control register read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 16 | Read data, valid while reg_rd is high |
| evt_in | input | 15 | Event pulses from the transceiver core |
| irq_out | output | 1 | Active-high interrupt |

## Verification
The collision that matters is a status read, which clears on read, landing in the same cycle as a new event pulse on the bit being cleared. The bench raises the event line and the read strobe in one cycle. It expects the read to return the old value and the following read to return the new bit. A second overlap is a mask or control write in the same cycle as a pending event. This is judged by sampling the interrupt output exactly one clock after the register edge, across a full sweep of every single-bit unmask against every event line.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
   localparam int unsigned ADDR_W    = 5;
   localparam int unsigned DATA_W    = 16;
   localparam int unsigned EVT_COUNT = 15;

   localparam logic [ADDR_W-1:0] A_CTRL   = 5'h10;
   localparam logic [ADDR_W-1:0] A_XSTAT  = 5'h11;
   localparam logic [ADDR_W-1:0] A_PEND   = 5'h1A;
   localparam logic [ADDR_W-1:0] A_MASK   = 5'h1B;

   localparam int unsigned CTRL_GMASK_BIT = 12;
   localparam int unsigned CTRL_FORCE_BIT = 11;
   localparam int unsigned XSTAT_IRQ_BIT  = 12;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_XSTAT,
      SEL_PEND,
      SEL_MASK
   } reg_sel_e;
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
   parameter int unsigned N_EVT = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_i,
   input  logic             clr_i,
   output logic [N_EVT-1:0] pend_o
);
   initial begin
      if (N_EVT < 1) $error("N_EVT must be at least 1");
   end

   for (genvar g = 0; g < N_EVT; g++) begin : g_bit
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        pend_q <= 1'b0;
         else if (evt_i[g]) pend_q <= 1'b1;
         else if (clr_i)    pend_q <= 1'b0;
      end
      assign pend_o[g] = pend_q;

      // R2: an event pulse always lands in its status bit
      a_r2_evt_latches: assert property (@(posedge clk) disable iff (!rst_n)
         evt_i[g] |=> pend_o[g]);
      // R4: a set bit survives until a read clears it
      a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_o[g] && !clr_i) |=> pend_o[g]);
      // R3: clear without a coincident event empties the bit
      a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && !evt_i[g]) |=> !pend_o[g]);
   end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
   parameter int unsigned DW        = 16,
   parameter int unsigned N_EVT     = 15,
   parameter int unsigned GMASK_BIT = 12,
   parameter int unsigned FORCE_BIT = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we_i,
   input  logic             mask_we_i,
   input  logic [DW-1:0]    wdata_i,
   output logic [DW-1:0]    ctrl_o,
   output logic [N_EVT-1:0] mask_o,
   output logic             gmask_o,
   output logic             force_o
);
   localparam logic [DW-1:0] CTRL_RST = DW'(1) << GMASK_BIT;

   initial begin
      if (N_EVT > DW)     $error("N_EVT exceeds data width");
      if (GMASK_BIT >= DW) $error("GMASK_BIT out of range");
      if (FORCE_BIT >= DW) $error("FORCE_BIT out of range");
      if (FORCE_BIT == GMASK_BIT) $error("control bits collide");
   end

   logic [DW-1:0]    ctrl_q;
   logic [N_EVT-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctrl_q <= CTRL_RST;
      else if (ctrl_we_i) ctrl_q <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '1;
      else if (mask_we_i) mask_q <= wdata_i[N_EVT-1:0];
   end

   assign ctrl_o  = ctrl_q;
   assign mask_o  = mask_q;
   assign gmask_o = ctrl_q[GMASK_BIT];
   assign force_o = ctrl_q[FORCE_BIT];

   // R10: control register holds whatever was written
   a_r10_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we_i |=> (ctrl_o == $past(wdata_i)));
   // R10: control register is stable without a write
   a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_we_i |=> $stable(ctrl_o));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
   parameter int unsigned N_EVT  = 15,
   parameter bit          OUT_FF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] pend_i,
   input  logic [N_EVT-1:0] mask_i,
   input  logic             force_i,
   input  logic             gmask_i,
   output logic             irq_o
);
   logic irq_d;

   always_comb begin
      irq_d = ((|(pend_i & ~mask_i)) | force_i) & ~gmask_i;
   end

   if (OUT_FF) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_d;
      end
      assign irq_o = irq_q;

      // R6: global mask silences the output on the following clock
      a_r6_gmask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         gmask_i |=> !irq_o);
      // R7: force with global mask clear raises the output
      a_r7_force_raises: assert property (@(posedge clk) disable iff (!rst_n)
         (force_i && !gmask_i) |=> irq_o);
      // R5: nothing unmasked, nothing forced -> quiet
      a_r5_no_source: assert property (@(posedge clk) disable iff (!rst_n)
         (((pend_i & ~mask_i) == '0) && !force_i) |=> !irq_o);
   end else begin : g_comb
      assign irq_o = irq_d;
   end
endmodule

// File: rtl/phy_irq_unit.sv
module phy_irq_unit
   import phy_irq_pkg::*;
#(
   parameter int unsigned AW     = ADDR_W,
   parameter int unsigned DW     = DATA_W,
   parameter int unsigned N_EVT  = EVT_COUNT,
   parameter bit          OUT_FF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [4:0]       reg_addr,
   input  logic [15:0]      reg_wdata,
   input  logic             reg_wr,
   input  logic             reg_rd,
   output logic [15:0]      reg_rdata,
   input  logic [14:0]      evt_in,
   output logic             irq_out
);
   localparam int unsigned PAD_W = DW - N_EVT;

   initial begin
      if (AW != 5)       $error("address width must be 5");
      if (DW != 16)      $error("data width must be 16");
      if (N_EVT != 15)   $error("event count must be 15");
      if (PAD_W < 1)     $error("need at least one spare status bit");
   end

   reg_sel_e         sel;
   logic [DW-1:0]    ctrl;
   logic [N_EVT-1:0] mask;
   logic [N_EVT-1:0] pend;
   logic             gmask;
   logic             force_irq;
   logic             pend_clr;

   always_comb begin
      unique case (reg_addr)
         A_CTRL:  sel = SEL_CTRL;
         A_XSTAT: sel = SEL_XSTAT;
         A_PEND:  sel = SEL_PEND;
         A_MASK:  sel = SEL_MASK;
         default: sel = SEL_NONE;
      endcase
   end

   assign pend_clr = reg_rd && (sel == SEL_PEND);

   irq_pend_latch #(.N_EVT(N_EVT)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_in),
      .clr_i  (pend_clr),
      .pend_o (pend)
   );

   irq_ctrl_regs #(
      .DW        (DW),
      .N_EVT     (N_EVT),
      .GMASK_BIT (CTRL_GMASK_BIT),
      .FORCE_BIT (CTRL_FORCE_BIT)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we_i (reg_wr && (sel == SEL_CTRL)),
      .mask_we_i (reg_wr && (sel == SEL_MASK)),
      .wdata_i   (reg_wdata),
      .ctrl_o    (ctrl),
      .mask_o    (mask),
      .gmask_o   (gmask),
      .force_o   (force_irq)
   );

   irq_combine #(.N_EVT(N_EVT), .OUT_FF(OUT_FF)) u_comb (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_i  (pend),
      .mask_i  (mask),
      .force_i (force_irq),
      .gmask_i (gmask),
      .irq_o   (irq_out)
   );

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_CTRL:  reg_rdata = ctrl;
         SEL_XSTAT: reg_rdata[XSTAT_IRQ_BIT] = irq_out;
         SEL_PEND:  reg_rdata = {{PAD_W{1'b0}}, pend};
         SEL_MASK:  reg_rdata = {{PAD_W{1'b0}}, mask};
         default:   reg_rdata = '0;
      endcase
   end

   // R8: extended status shows the live interrupt level
   a_r8_xstat_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_XSTAT) |-> (reg_rdata[XSTAT_IRQ_BIT] == irq_out));
   // R9: spare top bit of status never reads as set
   a_r9_pend_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_PEND) |-> !reg_rdata[DW-1]);
endmodule

// File: tb/phy_irq_unit_tb.sv
module phy_irq_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [15:0] reg_rdata;
   logic [14:0] evt_in = '0;
   logic        irq_out;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   phy_irq_unit u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata),
      .evt_in    (evt_in),
      .irq_out   (irq_out)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse(input logic [14:0] v);
      @(negedge clk);
      evt_in = v;
      @(negedge clk);
      evt_in = '0;
   endtask

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq", {15'd0, irq_out}, 16'h0000);
      rd(5'h10, d); chk("R1 ctrl", d, 16'h1000);
      rd(5'h1B, d); chk("R1 mask", d, 16'h7FFF);
      rd(5'h1A, d); chk("R1 pend", d, 16'h0000);

      // R2/R3: every event line latches despite full masking, read clears
      for (int i = 0; i < 15; i++) begin
         pulse(15'(1) << i);
         @(negedge clk);
         chk("R2 masked event leaves irq low", {15'd0, irq_out}, 16'h0000);
         rd(5'h1A, d); chk("R2 latch bit", d, 16'(1) << i);
         rd(5'h1A, d); chk("R3 cleared", d, 16'h0000);
      end

      // R3: multiple bits accumulate until read
      pulse(15'h0003); pulse(15'h4000);
      rd(5'h1A, d); chk("R3 accumulate", d, 16'h4003);

      // R4: event coincides with status read
      pulse(15'h0010);
      @(negedge clk);
      reg_addr = 5'h1A; reg_rd = 1'b1; evt_in = 15'h0100;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0; evt_in = '0;
      chk("R4 old value read", d, 16'h0010);
      rd(5'h1A, d); chk("R4 new event kept", d, 16'h0100);

      // R9: writes to status/xstat ignored, unmapped reads zero, bit15 zero
      pulse(15'h0004);
      wr(5'h1A, 16'h0000);
      wr(5'h11, 16'hFFFF);
      rd(5'h1A, d); chk("R9 pend write ignored", d, 16'h0004);
      rd(5'h05, d); chk("R9 unmapped", d, 16'h0000);
      rd(5'h1F, d); chk("R9 unmapped hi", d, 16'h0000);
      wr(5'h1B, 16'hFFFF);
      rd(5'h1B, d); chk("R9 mask bit15", d, 16'h7FFF);

      // R10 control readback
      wr(5'h10, 16'hA5A5);
      rd(5'h10, d); chk("R10 readback", d, 16'hA5A5);
      wr(5'h10, 16'h0000);
      rd(5'h10, d); chk("R10 readback zero", d, 16'h0000);

      // R5: sweep single unmasked bit against every event line
      for (int i = 0; i < 15; i++) begin
         wr(5'h1B, 16'h7FFF & ~(16'(1) << i));
         for (int j = 0; j < 15; j++) begin
            pulse(15'(1) << j);
            @(negedge clk);
            chk("R5 unmask sweep", {15'd0, irq_out}, (i == j) ? 16'h1 : 16'h0);
            rd(5'h1A, d);
            @(negedge clk);
            chk("R5 clear drops irq", {15'd0, irq_out}, 16'h0000);
         end
      end

      // R8: xstat mirrors irq
      wr(5'h1B, 16'h0000);
      pulse(15'h0002);
      @(negedge clk);
      chk("R5 irq up", {15'd0, irq_out}, 16'h0001);
      rd(5'h11, d); chk("R8 xstat high", d, 16'h1000);

      // R6: global mask with unmasked pending event
      wr(5'h10, 16'h1000);
      @(negedge clk);
      chk("R6 gmask holds low", {15'd0, irq_out}, 16'h0000);
      rd(5'h11, d); chk("R8 xstat low", d, 16'h0000);
      rd(5'h1A, d); chk("R6 event still latched", d, 16'h0002);

      // R7: force with no events
      wr(5'h1B, 16'h7FFF);
      wr(5'h10, 16'h0800);
      @(negedge clk);
      chk("R7 force raises", {15'd0, irq_out}, 16'h0001);
      rd(5'h1A, d); chk("R7 no pending", d, 16'h0000);
      wr(5'h10, 16'h1800);
      @(negedge clk);
      chk("R6 gmask beats force", {15'd0, irq_out}, 16'h0000);
      wr(5'h10, 16'h0000);
      @(negedge clk);
      chk("R7 force off", {15'd0, irq_out}, 16'h0000);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule